// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the programmer-visible register set of an 8-bit processor core. It has eight byte registers, A, F, B, C, D, E, H and L, and a second copy of all eight called the alternate bank. It also holds three 16-bit registers: two index registers, X and Y, and the stack pointer. The sequencer issues one command per clock cycle. A command either writes one byte register or one register pair, or it performs a higher-level operation. The higher-level operations are three exchanges and the pointer/counter step used by block-move loops. Each exchange and each block step finishes in a single cycle.

Two independent read ports show the selected register or pair combinationally. The commands are control, not a data stream, so there is no handshake. Every command is accepted on the clock edge where it is presented and never stalls. Its result is visible on the read ports from the following cycle.

Top module: `dualbank_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every register reads as zero, except the stack pointer, which reads 16'hFFFF. Reset is active low.
- R2: When `op_i`=1, the byte register given by `sel_i` is written with `wdata_i[7:0]`. The codes are B=0, C=1, D=2, E=3, H=4, L=5, F=6, A=7. No other register changes. A byte read (`rd_*_sel_i[3]`=0, low bits use the same codes) returns the value in bits 7:0 with bits 15:8 zero.
- R3: When `op_i`=2, the pair given by `sel_i` is written with `wdata_i`. The codes are BC=0, DE=1, HL=2, AF=3. The first-named register takes bits 15:8. A pair read (`rd_*_sel_i[3]`=1) uses the same codes.
- R4: Both read ports decode their selects independently and can show different registers in the same cycle.
- R5: `op_i`=3 exchanges A and F with their alternates and leaves all other registers unchanged. Issuing it twice restores the original values.
- R6: `op_i`=4 exchanges BC, DE and HL with their alternates in one cycle. A and F are untouched.
- R7: `op_i`=5 swaps the DE and HL pairs of the active bank. The alternate bank is untouched.
- R8: `op_i`=6 decrements BC in one cycle. In the same cycle it increments HL and DE when `blk_dec_i`=0, or decrements them when `blk_dec_i`=1. All three wrap modulo 2^16.
- R9: The 16-bit registers are written only by a pair write with code X=4, Y=5 or SP=6. They read back through pair codes 4, 5 and 6, and no byte write reaches them.
- R10: `op_i`=0 and the reserved `op_i`=7 leave every register unchanged. A pair write with `sel_i`=7 also changes nothing, and pair read code 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command code |
| sel_i | input | 3 | Target register or pair for writes |
| wdata_i | input | 16 | Write data |
| blk_dec_i | input | 1 | Block step direction (1 = decrement HL/DE) |
| rd_a_sel_i | input | 4 | Read port A select: bit 3 pair/byte, bits 2:0 code |
| rd_a_o | output | 16 | Read port A data |
| rd_b_sel_i | input | 4 | Read port B select |
| rd_b_o | output | 16 | Read port B data |

## Verification
The hardest situation to reach from the ports is an alternate bank that holds values the bench can tell apart from the active bank, reached after a mixed sequence of exchanges and pair swaps. The bank the ports see depends on how many exchanges of each kind have occurred, and the sequence interleaves writes that land in whichever bank is active. The stimulus draws long random runs over all eight command codes with byte and pair writes between exchanges. The bench compares every read select on both ports after each command against a model that physically swaps values. Directed steps drive BC, DE and HL to 0000 and FFFF so that the block step crosses its wrap points in both directions.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WR8   = 3'd1,
    OP_WR16  = 3'd2,
    OP_XAF   = 3'd3,
    OP_XBANK = 3'd4,
    OP_XDEHL = 3'd5,
    OP_BLK   = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  localparam logic [2:0] R8_F = 3'd6;
  localparam logic [2:0] R8_A = 3'd7;

  localparam logic [2:0] P_BC = 3'd0;
  localparam logic [2:0] P_DE = 3'd1;
  localparam logic [2:0] P_HL = 3'd2;
  localparam logic [2:0] P_AF = 3'd3;
  localparam logic [2:0] P_IX = 3'd4;
  localparam logic [2:0] P_IY = 3'd5;
  localparam logic [2:0] P_SP = 3'd6;

  localparam int GP_PAIRS = 3;
endpackage

// File: rtl/dbrf_gpbank.sv
module dbrf_gpbank
  import dbrf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 op,
  input  logic [2:0]          sel,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic                blk_dec,
  output logic [2*BYTE_W-1:0] bc,
  output logic [2*BYTE_W-1:0] de,
  output logic [2*BYTE_W-1:0] hl
);
  localparam int PW = 2 * BYTE_W;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pr [2][GP_PAIRS];
  logic          bank;
  logic [PW-1:0] step;
  logic [PW-1:0] bc_n, de_n, hl_n;
  logic [PW-1:0] bc_alt, de_alt, hl_alt;

  assign bc     = pr[bank][0];
  assign de     = pr[bank][1];
  assign hl     = pr[bank][2];
  assign bc_alt = pr[~bank][0];
  assign de_alt = pr[~bank][1];
  assign hl_alt = pr[~bank][2];

  always_comb begin
    step = blk_dec ? ~'0 : ONE;
    bc_n = bc - ONE;
    de_n = de + step;
    hl_n = hl + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < GP_PAIRS; k++)
          pr[b][k] <= '0;
    end else begin
      case (op)
        OP_WR8: begin
          if (sel < 3'd6) begin
            if (sel[0] == 1'b0) pr[bank][sel[2:1]][PW-1:BYTE_W] <= wdata[BYTE_W-1:0];
            else                pr[bank][sel[2:1]][BYTE_W-1:0]  <= wdata[BYTE_W-1:0];
          end
        end
        OP_WR16: begin
          if (sel < 3'd3) pr[bank][sel[1:0]] <= wdata;
        end
        OP_XBANK: bank <= ~bank;
        OP_XDEHL: begin
          pr[bank][1] <= hl;
          pr[bank][2] <= de;
        end
        OP_BLK: begin
          pr[bank][0] <= bc_n;
          pr[bank][1] <= de_n;
          pr[bank][2] <= hl_n;
        end
        default: ;
      endcase
    end
  end

  p_xbank_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XBANK |=> (bc == $past(bc_alt) && de == $past(de_alt) && hl == $past(hl_alt)
                        && bc_alt == $past(bc) && hl_alt == $past(hl)));

  p_xdehl_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XDEHL |=> (de == $past(hl) && hl == $past(de) && bc == $past(bc)
                        && de_alt == $past(de_alt) && hl_alt == $past(hl_alt)));

  p_blk_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_BLK |=> (bc == $past(bc) - ONE && bc_alt == $past(bc_alt)));

  p_gp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || op == OP_RSVD || op == OP_XAF) |=>
      (bc == $past(bc) && de == $past(de) && hl == $past(hl) && bc_alt == $past(bc_alt)));
endmodule

// File: rtl/dbrf_afbank.sv
module dbrf_afbank
  import dbrf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 op,
  input  logic [2:0]          sel,
  input  logic [2*BYTE_W-1:0] wdata,
  output logic [2*BYTE_W-1:0] af
);
  localparam int PW = 2 * BYTE_W;

  logic [PW-1:0] pr [2];
  logic          bank;
  logic [PW-1:0] af_alt;

  assign af     = pr[bank];
  assign af_alt = pr[~bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank  <= 1'b0;
      pr[0] <= '0;
      pr[1] <= '0;
    end else begin
      case (op)
        OP_WR8: begin
          if (sel == R8_A)      pr[bank][PW-1:BYTE_W] <= wdata[BYTE_W-1:0];
          else if (sel == R8_F) pr[bank][BYTE_W-1:0]  <= wdata[BYTE_W-1:0];
        end
        OP_WR16: if (sel == P_AF) pr[bank] <= wdata;
        OP_XAF:  bank <= ~bank;
        default: ;
      endcase
    end
  end

  p_xaf_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_XAF |=> (af == $past(af_alt) && af_alt == $past(af)));

  p_af_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || op == OP_RSVD || op == OP_XBANK || op == OP_BLK || op == OP_XDEHL) |=>
      (af == $past(af) && af_alt == $past(af_alt)));
endmodule

// File: rtl/dbrf_wide.sv
module dbrf_wide
  import dbrf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  op_e                 op,
  input  logic [2:0]          sel,
  input  logic [2*BYTE_W-1:0] wdata,
  output logic [2*BYTE_W-1:0] ix,
  output logic [2*BYTE_W-1:0] iy,
  output logic [2*BYTE_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ix <= '0;
      iy <= '0;
      sp <= '1;
    end else if (op == OP_WR16) begin
      case (sel)
        P_IX:    ix <= wdata;
        P_IY:    iy <= wdata;
        P_SP:    sp <= wdata;
        default: ;
      endcase
    end
  end

  p_wide_only_wr16_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_WR16 |=> (ix == $past(ix) && iy == $past(iy) && sp == $past(sp)));
endmodule

// File: rtl/dbrf_rdmux.sv
module dbrf_rdmux #(
  parameter int BYTE_W = 8
) (
  input  logic [3:0]          sel,
  input  logic [2*BYTE_W-1:0] bc,
  input  logic [2*BYTE_W-1:0] de,
  input  logic [2*BYTE_W-1:0] hl,
  input  logic [2*BYTE_W-1:0] af,
  input  logic [2*BYTE_W-1:0] ix,
  input  logic [2*BYTE_W-1:0] iy,
  input  logic [2*BYTE_W-1:0] sp,
  output logic [2*BYTE_W-1:0] q
);
  localparam int PW = 2 * BYTE_W;

  always_comb begin
    q = '0;
    if (sel[3]) begin
      case (sel[2:0])
        3'd0: q = bc;
        3'd1: q = de;
        3'd2: q = hl;
        3'd3: q = af;
        3'd4: q = ix;
        3'd5: q = iy;
        3'd6: q = sp;
        default: q = '0;
      endcase
    end else begin
      case (sel[2:0])
        3'd0: q[BYTE_W-1:0] = bc[PW-1:BYTE_W];
        3'd1: q[BYTE_W-1:0] = bc[BYTE_W-1:0];
        3'd2: q[BYTE_W-1:0] = de[PW-1:BYTE_W];
        3'd3: q[BYTE_W-1:0] = de[BYTE_W-1:0];
        3'd4: q[BYTE_W-1:0] = hl[PW-1:BYTE_W];
        3'd5: q[BYTE_W-1:0] = hl[BYTE_W-1:0];
        3'd6: q[BYTE_W-1:0] = af[BYTE_W-1:0];
        default: q[BYTE_W-1:0] = af[PW-1:BYTE_W];
      endcase
    end
  end
endmodule

// File: rtl/dualbank_regfile.sv
module dualbank_regfile
  import dbrf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PW     = 2 * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [2:0]    sel_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          blk_dec_i,
  input  logic [3:0]    rd_a_sel_i,
  output logic [PW-1:0] rd_a_o,
  input  logic [3:0]    rd_b_sel_i,
  output logic [PW-1:0] rd_b_o
);
  localparam int NRD = 2;

  op_e           op;
  logic [PW-1:0] bc, de, hl, af, ix, iy, sp;
  logic [3:0]    rsel [NRD];
  logic [PW-1:0] rq   [NRD];

  assign op      = op_e'(op_i);
  assign rsel[0] = rd_a_sel_i;
  assign rsel[1] = rd_b_sel_i;
  assign rd_a_o  = rq[0];
  assign rd_b_o  = rq[1];

  dbrf_gpbank #(.BYTE_W(BYTE_W)) u_gp (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel_i), .wdata(wdata_i),
    .blk_dec(blk_dec_i), .bc(bc), .de(de), .hl(hl)
  );

  dbrf_afbank #(.BYTE_W(BYTE_W)) u_af (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel_i), .wdata(wdata_i), .af(af)
  );

  dbrf_wide #(.BYTE_W(BYTE_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .op(op), .sel(sel_i), .wdata(wdata_i),
    .ix(ix), .iy(iy), .sp(sp)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    dbrf_rdmux #(.BYTE_W(BYTE_W)) u_mux (
      .sel(rsel[p]), .bc(bc), .de(de), .hl(hl), .af(af),
      .ix(ix), .iy(iy), .sp(sp), .q(rq[p])
    );
  end

  p_rd8_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_sel_i[3] |-> rd_a_o[PW-1:BYTE_W] == '0);

  p_wr8_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR8 && sel_i == R8_A) |=> af[PW-1:BYTE_W] == $past(wdata_i[BYTE_W-1:0]));
endmodule

// File: tb/tb_dualbank_regfile.sv
`timescale 1ns/10ps
module tb_dualbank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [2:0]  sel_i = '0;
  logic [15:0] wdata_i = '0;
  logic        blk_dec_i = 1'b0;
  logic [3:0]  rd_a_sel_i = '0;
  logic [3:0]  rd_b_sel_i = '0;
  logic [15:0] rd_a_o, rd_b_o;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0]  mn [8];
  logic [7:0]  al [8];
  logic [15:0] mix, miy, msp;

  always #4 clk = ~clk;

  dualbank_regfile dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i), .wdata_i(wdata_i),
    .blk_dec_i(blk_dec_i), .rd_a_sel_i(rd_a_sel_i), .rd_a_o(rd_a_o),
    .rd_b_sel_i(rd_b_sel_i), .rd_b_o(rd_b_o)
  );

  function automatic logic [15:0] exp_read(input logic [3:0] s);
    if (s[3]) begin
      case (s[2:0])
        3'd0: return {mn[0], mn[1]};
        3'd1: return {mn[2], mn[3]};
        3'd2: return {mn[4], mn[5]};
        3'd3: return {mn[7], mn[6]};
        3'd4: return mix;
        3'd5: return miy;
        3'd6: return msp;
        default: return 16'h0000;
      endcase
    end
    return {8'h00, mn[s[2:0]]};
  endfunction

  function automatic string tag_for(input logic [2:0] op, input logic [2:0] s);
    case (op)
      3'd1: return "R2";
      3'd2: return (s == 3'd7) ? "R10" : ((s >= 3'd4) ? "R9" : "R3");
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model_apply(input logic [2:0] op, input logic [2:0] s,
                             input logic [15:0] d, input logic dec);
    logic [7:0] t;
    logic [15:0] bcv, dev, hlv, stp;
    case (op)
      3'd1: mn[s] = d[7:0];
      3'd2: case (s)
        3'd0: begin mn[0] = d[15:8]; mn[1] = d[7:0]; end
        3'd1: begin mn[2] = d[15:8]; mn[3] = d[7:0]; end
        3'd2: begin mn[4] = d[15:8]; mn[5] = d[7:0]; end
        3'd3: begin mn[7] = d[15:8]; mn[6] = d[7:0]; end
        3'd4: mix = d;
        3'd5: miy = d;
        3'd6: msp = d;
        default: ;
      endcase
      3'd3: for (int i = 6; i < 8; i++) begin t = mn[i]; mn[i] = al[i]; al[i] = t; end
      3'd4: for (int i = 0; i < 6; i++) begin t = mn[i]; mn[i] = al[i]; al[i] = t; end
      3'd5: begin
        t = mn[2]; mn[2] = mn[4]; mn[4] = t;
        t = mn[3]; mn[3] = mn[5]; mn[5] = t;
      end
      3'd6: begin
        stp = dec ? 16'hFFFF : 16'h0001;
        bcv = {mn[0], mn[1]} - 16'h0001;
        dev = {mn[2], mn[3]} + stp;
        hlv = {mn[4], mn[5]} + stp;
        {mn[0], mn[1]} = bcv;
        {mn[2], mn[3]} = dev;
        {mn[4], mn[5]} = hlv;
      end
      default: ;
    endcase
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag,
                       input logic [3:0] s);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%h actual=%h expected=%h", tag, s, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 16; k++) begin
      rd_a_sel_i = 4'(k);
      rd_b_sel_i = 4'(15 - k);
      #0.1;
      check(rd_a_o, exp_read(4'(k)), tag, 4'(k));
      check(rd_b_o, exp_read(4'(15 - k)), "R4", 4'(15 - k));
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [2:0] s,
                       input logic [15:0] d, input logic dec);
    @(negedge clk);
    op_i = op; sel_i = s; wdata_i = d; blk_dec_i = dec;
    @(posedge clk);
    #1;
    op_i = 3'd0;
    model_apply(op, s, d, dec);
    sweep(tag_for(op, s));
  endtask

  initial begin
    #(8.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] op;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mn[i] = 8'h00; al[i] = 8'h00; end
    mix = 16'h0000; miy = 16'h0000; msp = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    sweep("R1");                         // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    sweep("R1");                         // R1 after release

    // R2 / R3 / R9 directed writes
    for (int i = 0; i < 8; i++) do_op(3'd1, 3'(i), {8'hEE, 8'(8'h11 * (i + 1))}, 1'b0);
    do_op(3'd2, 3'd3, 16'hA55A, 1'b0);   // R3 AF: A takes high byte
    do_op(3'd2, 3'd4, 16'h1234, 1'b0);   // R9
    do_op(3'd2, 3'd5, 16'h5678, 1'b0);   // R9
    do_op(3'd2, 3'd6, 16'h9ABC, 1'b0);   // R9
    do_op(3'd2, 3'd7, 16'hDEAD, 1'b0);   // R10 ignored code
    do_op(3'd7, 3'd0, 16'hBEEF, 1'b0);   // R10 reserved op
    // R5 / R6 / R7
    do_op(3'd3, 3'd0, 16'h0, 1'b0);
    do_op(3'd2, 3'd3, 16'h0F0F, 1'b0);
    do_op(3'd3, 3'd0, 16'h0, 1'b0);
    do_op(3'd4, 3'd0, 16'h0, 1'b0);
    do_op(3'd2, 3'd1, 16'h7777, 1'b0);
    do_op(3'd5, 3'd0, 16'h0, 1'b0);
    do_op(3'd4, 3'd0, 16'h0, 1'b0);
    // R8 wrap corners
    do_op(3'd2, 3'd0, 16'h0000, 1'b0);
    do_op(3'd2, 3'd1, 16'h0000, 1'b0);
    do_op(3'd2, 3'd2, 16'hFFFF, 1'b0);
    do_op(3'd6, 3'd0, 16'h0, 1'b0);      // BC->FFFF, DE->0001, HL->0000
    do_op(3'd2, 3'd1, 16'h0000, 1'b0);
    do_op(3'd6, 3'd0, 16'h0, 1'b1);      // DE->FFFF, HL->FFFF
    do_op(3'd6, 3'd0, 16'h0, 1'b0);      // HL wraps to 0000

    // random mix
    for (int n = 0; n < 3000; n++) begin
      op = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: d = 16'h0000;
        1: d = 16'hFFFF;
        default: d = 16'($urandom);
      endcase
      do_op(op, 3'($urandom_range(0, 7)), d, 1'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule